// File: doc/BRIEF.md
# Stereo Soft-Mute Ramp with Long Zero-Run Flag

This block sits in the digital datapath of an audio converter, in front of the interpolation stage. Each frame delivers one signed left sample and one signed right sample together with a one-cycle valid strobe. Both samples are multiplied by a shared gain and rounded. The gain moves gradually between unity and silence under a mute request. The ramp advances once per valid frame, so its duration is a number of frames. That number doubles at each step up in speed mode, which keeps the ramp's duration in time about the same.

Beside the gain path, a watcher counts consecutive frames in which both channels carry exactly zero. After a long unbroken run it raises a flag. The flag drops as soon as a non-zero frame arrives. A run input set low places the block in its idle state: the gain goes back to unity, the outputs go to zero and the zero-run history is cleared.

Top module: `msr_softmute`

## Requirements
- R1: With `i_speed` = 2'b00 (normal, also used for the unused code 2'b11), holding `i_mute` high moves the gain from unity (4096/4096) to zero in 1024 valid frames. The gain applied to a frame is the value held before that frame's step: muted frame k (k from 1) is scaled by (4096-4*(k-1))/4096, and frame 1025 onward is exactly zero.
- R2: With `i_speed` = 2'b01 the gain changes by 2/4096 per frame, giving a 2048-frame ramp. With 2'b10 it changes by 1/4096 per frame, giving a 4096-frame ramp.
- R3: With `i_mute` low, the gain climbs back toward unity by the same per-frame step and stops at unity.
- R4: When the mute request is dropped part way down a ramp, the gain turns around from its current level and climbs back at the same rate. Raising mute part way up turns it downward the same way.
- R5: Each output is round(sample × gain / 4096), with halves rounded toward +∞, and is clamped to the signed 24-bit range. At unity the output equals the input, and at zero gain the output is exactly 0.
- R6: `o_zero` goes high once both inputs have been exactly zero on 8192 consecutive valid frames. The run counter saturates, so the flag stays high while the zero frames continue.
- R7: `o_zero` is low in the cycle after any valid frame in which either channel is non-zero, and the run count restarts from 0.
- R8: While `i_run` is low, `o_zero` is low, the run count is cleared, the gain returns to unity and the outputs are held at zero.
- R9: Cycles without `i_valid` change neither the gain nor the zero-run count.
- R10: Outputs are registered. `o_valid` pulses in the cycle after an accepted frame, and `o_left`/`o_right` hold that frame's result until the next accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_run | input | 1 | High for normal operation, low for the idle state |
| i_valid | input | 1 | One-cycle strobe per frame |
| i_mute | input | 1 | Mute request, high ramps the gain to silence |
| i_speed | input | 2 | 00 normal, 01 double, 10 quad, 11 treated as normal |
| i_left | input | 24 | Left sample, two's complement |
| i_right | input | 24 | Right sample, two's complement |
| o_valid | output | 1 | Result strobe |
| o_left | output | 24 | Attenuated left sample |
| o_right | output | 24 | Attenuated right sample |
| o_zero | output | 1 | Long zero-run flag |

## Verification
On every cycle the embedded properties check the following:
- the gain stays within range and only moves in the direction the mute request asks for;
- the gain holds still between strobes;
- a zero gain yields a zero output;
- the flag drops after a non-zero frame or while idle;
- the run counter never passes its limit.

Only the directed scenarios can show the rest:
- the exact ramp lengths for each speed code;
- the level at which a reversed ramp turns;
- the rounding and clamping of extreme samples;
- the precise frame on which the zero flag rises.

// File: rtl/msr_pkg.sv
package msr_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_SPARE  = 2'b11
   } msr_speed_e;

   localparam int unsigned MSR_CHANNELS = 2;

   // Per-frame gain step for a speed code, as a shift of one unit.
   function automatic int unsigned msr_step_shift(input logic [1:0] spd);
      case (spd)
         SPD_DOUBLE: return 1;
         SPD_QUAD:   return 0;
         default:    return 2;
      endcase
   endfunction

endpackage

// File: rtl/msr_gain_ramp.sv
module msr_gain_ramp
   import msr_pkg::*;
#(
   parameter int unsigned GAIN_FRAC = 12,
   localparam int unsigned G_W     = GAIN_FRAC + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           valid,
   input  logic           mute,
   input  logic [1:0]     speed,
   output logic [G_W-1:0] gain
);

   localparam logic [G_W-1:0] G_MAX = G_W'(1) << GAIN_FRAC;

   logic [G_W-1:0] step;
   logic [G_W-1:0] room;
   logic [G_W-1:0] g_q;

   always_comb begin
      step = G_W'(1) << msr_step_shift(speed);
      room = G_MAX - g_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_q <= G_MAX;
      end else if (!run) begin
         g_q <= G_MAX;
      end else if (valid) begin
         if (mute) begin
            g_q <= (g_q > step) ? (g_q - step) : '0;
         end else begin
            g_q <= (room > step) ? (g_q + step) : G_MAX;
         end
      end
   end

   assign gain = g_q;

   p_gain_range_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      g_q <= G_MAX);

   p_fall_on_mute_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      run && valid && mute |=> g_q <= $past(g_q));

   p_rise_on_release_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      run && valid && !mute |=> g_q >= $past(g_q));

   p_hold_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      run && !valid |=> $stable(g_q));

endmodule

// File: rtl/msr_chan_scale.sv
module msr_chan_scale #(
   parameter int unsigned DATA_W    = 24,
   parameter int unsigned GAIN_FRAC = 12,
   localparam int unsigned G_W      = GAIN_FRAC + 1,
   localparam int unsigned P_W      = DATA_W + G_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              valid,
   input  logic [DATA_W-1:0] sample,
   input  logic [G_W-1:0]    gain,
   output logic [DATA_W-1:0] result
);

   localparam logic signed [P_W-1:0] HALF = P_W'(1) << (GAIN_FRAC - 1);
   localparam logic signed [P_W-1:0] MAXV = {{(P_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [P_W-1:0] MINV = ~MAXV;

   logic signed [P_W-1:0] prod;
   logic signed [P_W-1:0] shifted;
   logic [DATA_W-1:0]     clamped;
   logic [DATA_W-1:0]     res_q;

   always_comb begin
      prod    = $signed(sample) * $signed({1'b0, gain});
      shifted = (prod + HALF) >>> GAIN_FRAC;
      if (shifted > MAXV)      clamped = MAXV[DATA_W-1:0];
      else if (shifted < MINV) clamped = MINV[DATA_W-1:0];
      else                     clamped = shifted[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        res_q <= '0;
      else if (!run)     res_q <= '0;
      else if (valid)    res_q <= clamped;
   end

   assign result = res_q;

   p_silent_at_zero_gain_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      run && valid && (gain == '0) |=> res_q == '0);

   p_idle_output_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> res_q == '0);

endmodule

// File: rtl/msr_zero_watch.sv
module msr_zero_watch #(
   parameter int unsigned ZERO_RUN = 8192,
   localparam int unsigned ZC_W    = $clog2(ZERO_RUN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic valid,
   input  logic all_zero,
   output logic flag
);

   localparam logic [ZC_W-1:0] LIMIT = ZC_W'(ZERO_RUN);

   logic [ZC_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (valid) begin
         if (!all_zero)          cnt_q <= '0;
         else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign flag = run && (cnt_q == LIMIT);

   p_count_saturates_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   p_clear_on_data_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      run && valid && !all_zero |=> !flag);

   p_low_when_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !flag);

   p_count_holds_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      run && !valid |=> $stable(cnt_q));

endmodule

// File: rtl/msr_softmute.sv
module msr_softmute
   import msr_pkg::*;
#(
   parameter int unsigned DATA_W    = 24,
   parameter int unsigned GAIN_FRAC = 12,
   parameter int unsigned ZERO_RUN  = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_run,
   input  logic              i_valid,
   input  logic              i_mute,
   input  logic [1:0]        i_speed,
   input  logic [DATA_W-1:0] i_left,
   input  logic [DATA_W-1:0] i_right,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_left,
   output logic [DATA_W-1:0] o_right,
   output logic              o_zero
);

   localparam int unsigned G_W = GAIN_FRAC + 1;

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("msr_softmute: DATA_W must lie in 8..32");
   end
   if (GAIN_FRAC < 2 || GAIN_FRAC > 20) begin : g_bad_frac
      $error("msr_softmute: GAIN_FRAC must lie in 2..20");
   end
   if (ZERO_RUN < 2) begin : g_bad_run
      $error("msr_softmute: ZERO_RUN must be at least 2");
   end

   logic [G_W-1:0]    gain;
   logic [DATA_W-1:0] chan_in  [MSR_CHANNELS];
   logic [DATA_W-1:0] chan_out [MSR_CHANNELS];
   logic              valid_q;
   logic              both_zero;

   assign chan_in[0] = i_left;
   assign chan_in[1] = i_right;
   assign both_zero  = (i_left == '0) && (i_right == '0);

   msr_gain_ramp #(.GAIN_FRAC(GAIN_FRAC)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (i_run),
      .valid (i_valid),
      .mute  (i_mute),
      .speed (i_speed),
      .gain  (gain)
   );

   for (genvar ch = 0; ch < MSR_CHANNELS; ch++) begin : g_chan
      msr_chan_scale #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_scale (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (i_run),
         .valid  (i_valid),
         .sample (chan_in[ch]),
         .gain   (gain),
         .result (chan_out[ch])
      );
   end

   msr_zero_watch #(.ZERO_RUN(ZERO_RUN)) u_zero (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (i_run),
      .valid    (i_valid),
      .all_zero (both_zero),
      .flag     (o_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= i_run && i_valid;
   end

   assign o_valid = valid_q;
   assign o_left  = chan_out[0];
   assign o_right = chan_out[1];

   p_strobe_follows_frame_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> $past(i_valid && i_run));

   p_output_stable_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      i_run && $past(i_run) && !$past(i_valid) |-> $stable(o_left) && $stable(o_right));

endmodule

// File: tb/msr_softmute_tb_top.sv
module msr_softmute_tb_top;

   localparam int GMAX = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_run = 1'b0;
   logic        i_valid = 1'b0;
   logic        i_mute = 1'b0;
   logic [1:0]  i_speed = 2'b00;
   logic [23:0] i_left = '0;
   logic [23:0] i_right = '0;
   logic        o_valid;
   logic [23:0] o_left;
   logic [23:0] o_right;
   logic        o_zero;

   int n_checks = 0;
   int n_fail   = 0;
   int mgain    = GMAX;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   msr_softmute dut_i (
      .clk(clk), .rst_n(rst_n), .i_run(i_run), .i_valid(i_valid),
      .i_mute(i_mute), .i_speed(i_speed), .i_left(i_left), .i_right(i_right),
      .o_valid(o_valid), .o_left(o_left), .o_right(o_right), .o_zero(o_zero)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] scale(input logic [23:0] s, input int g);
      longint p;
      longint r;
      p = longint'($signed(s)) * g;
      r = (p + 2048) >>> 12;
      if (r > 64'sd8388607)  r = 8388607;
      if (r < -64'sd8388608) r = -8388608;
      return r[23:0];
   endfunction

   function automatic int step_of(input logic [1:0] sp);
      case (sp)
         2'b01:   return 2;
         2'b10:   return 1;
         default: return 4;
      endcase
   endfunction

   // One frame; checks both outputs against the bench model.
   task automatic frame(input logic [23:0] l, input logic [23:0] r, input string req,
                        input bit chk);
      logic [23:0] el, er;
      el = scale(l, mgain);
      er = scale(r, mgain);
      @(negedge clk);
      i_left = l; i_right = r; i_valid = 1'b1;
      @(negedge clk);
      i_valid = 1'b0;
      if (i_mute) mgain = (mgain > step_of(i_speed)) ? mgain - step_of(i_speed) : 0;
      else        mgain = (GMAX - mgain > step_of(i_speed)) ? mgain + step_of(i_speed) : GMAX;
      if (chk) begin
         check({req, " o_valid"}, o_valid, 1);
         check({req, " left"},  o_left,  el);
         check({req, " right"}, o_right, er);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      i_run = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 idle flag", o_zero, 0);
      check("R8 idle left", o_left, 0);
      check("R8 idle right", o_right, 0);
      i_run = 1'b1;
      mgain = GMAX;
   endtask

   task automatic t_reset();
      check("R10 reset o_valid", o_valid, 0);
      check("R8 reset o_zero", o_zero, 0);
      check("R8 reset left", o_left, 0);
   endtask

   task automatic t_unity();
      i_mute = 1'b0; i_speed = 2'b00;
      frame(24'h7FFFFF, 24'h800000, "R5 unity extremes", 1);
      frame(24'h123457, 24'hFEDCBA, "R5 unity mixed", 1);
      @(negedge clk);
      check("R10 strobe one cycle", o_valid, 0);
      check("R10 hold left", o_left, 24'h123457);
   endtask

   task automatic t_ramp(input logic [1:0] sp, input int len, input string req);
      i_speed = sp; i_mute = 1'b1;
      for (int k = 1; k <= len + 2; k++) begin
         frame(24'h7FFFFF, 24'h800000, req, 1);
         if (k == len)     check({req, " last nonzero"}, (o_left != 0), 1);
         if (k == len + 1) check({req, " silent"}, o_left, 0);
      end
      i_mute = 1'b0;
      for (int k = 1; k <= len + 2; k++) begin
         frame(24'h7FFFFF, 24'h800000, "R3 release", 1);
         if (k == len + 1) check("R3 back to unity", o_left, 24'h7FFFFF);
      end
   endtask

   task automatic t_reverse();
      i_speed = 2'b00; i_mute = 1'b1;
      for (int k = 0; k < 300; k++) frame(24'h400000, 24'hC00001, "R4 down", 1);
      i_mute = 1'b0;
      for (int k = 0; k < 100; k++) frame(24'h400000, 24'hC00001, "R4 turn up", 1);
      i_mute = 1'b1;
      for (int k = 0; k < 50; k++)  frame(24'h400000, 24'hC00001, "R4 turn down", 1);
      i_mute = 1'b0;
      for (int k = 0; k < 260; k++) frame(24'h400000, 24'hC00001, "R4 recover", 1);
      check("R4 recovered gain", mgain, GMAX);
   endtask

   task automatic t_no_valid();
      i_mute = 1'b1;
      repeat (50) @(negedge clk);
      i_mute = 1'b0;
      frame(24'h7FFFFF, 24'h000001, "R9 gain unchanged", 1);
      check("R9 full scale kept", o_left, 24'h7FFFFF);
   endtask

   task automatic t_zero();
      go_idle();
      for (int k = 1; k <= 8192; k++) begin
         frame(24'h0, 24'h0, "R6 zero run", 0);
         if (k == 8191) check("R6 not yet", o_zero, 0);
         if (k == 8192) check("R6 set", o_zero, 1);
      end
      repeat (30) @(negedge clk);
      check("R9 flag held w/o valid", o_zero, 1);
      for (int k = 0; k < 200; k++) frame(24'h0, 24'h0, "R6 saturate", 0);
      check("R6 still set", o_zero, 1);
      frame(24'h0, 24'h000001, "R7 right nonzero", 1);
      check("R7 cleared", o_zero, 0);
      frame(24'h0, 24'h0, "R7 restart", 0);
      check("R7 count restarted", o_zero, 0);
      for (int k = 0; k < 8192; k++) frame(24'h0, 24'h0, "R6 again", 0);
      check("R6 set again", o_zero, 1);
      go_idle();
      frame(24'h0, 24'h0, "R8 after idle", 0);
      check("R8 history cleared", o_zero, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      i_run = 1'b1;
      @(negedge clk);
      t_unity();
      t_ramp(2'b00, 1024, "R1 normal");
      t_ramp(2'b01, 2048, "R2 double");
      t_ramp(2'b10, 4096, "R2 quad");
      t_ramp(2'b11, 1024, "R1 spare code");
      t_reverse();
      t_no_valid();
      t_zero();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule